// File: doc/BRIEF.md
# Gapless Laser Pulse Sequencer

This block turns a stream of per-pixel commands from a processor into a single laser gate signal. Every command describes one pixel with two counts in clock cycles: a mark time, during which the gate is high, and a period length, the whole time the pixel occupies. The fraction of the period spent high sets the grey level of that pixel. Commands enter a small queue in the cycle they are offered, so the processor never waits. The pulse engine pulls the next entry in the final cycle of the running period, which lets one period start directly after the previous one ends.

The engine is a three-state machine. PS_IDLE means no period is running. PS_MARK drives the gate high. PS_SPACE holds it low for the rest of the period. The transitions are:
- IDLE->MARK and IDLE->SPACE: load when the queue is not empty. The mark time picks which of the two states is entered.
- MARK->SPACE: the mark time has been used up and period cycles remain.
- MARK/SPACE->MARK/SPACE: reload in the last period cycle when another entry is waiting.
- MARK/SPACE->IDLE: the period ends with the queue empty. This is an underrun.

Two sticky flags report faults. One marks commands that were lost because the queue was full. The other marks a period that ended with nothing queued behind it. A single clear input resets both flags.

Top module: `pixel_pulse_sequencer`

## Requirements
- R1: While the queue holds fewer than DEPTH (default 4) entries, cmd_accept is high. A command offered with cmd_valid in that cycle is taken in that same cycle, with no wait.
- R2: A period of L cycles keeps laser_on high for its first min(M, L) cycles and low for the remaining cycles, where M is the mark time.
- R3: A mark time of 0 gives a period that is low throughout. A mark time equal to or larger than the period length gives a period that is high throughout.
- R4: If a command is queued before the last cycle of a running period, its period starts in the very next cycle. busy then stays high with no gap, and the periods follow in queue order.
- R5: From idle, a command offered in cycle k starts its period in cycle k+2.
- R6: queue_full is high when DEPTH entries are stored. A command offered while the queue is full is dropped, and the sticky overflow flag is set.
- R7: When a period ends with the queue empty, laser_on and busy go low and the sticky underrun flag is set. Both sticky flags stay set until clr_flags is asserted. If a set and a clear happen in the same cycle, the set wins.
- R8: A command with a period length of 0 is accepted and then discarded. It takes no queue slot and produces no output cycle.
- R9: busy is high exactly in the cycles in which a period is running, and laser_on is never high while busy is low.
- R10: After reset, laser_on, busy, queue_full, underrun and overflow are low and cmd_accept is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A pixel command is offered this cycle |
| cmd_on | input | CNT_W | Mark time in cycles |
| cmd_len | input | CNT_W | Period length in cycles |
| clr_flags | input | 1 | Clears the sticky underrun and overflow flags |
| cmd_accept | output | 1 | The queue has room this cycle |
| laser_on | output | 1 | Laser gate |
| busy | output | 1 | A period is running |
| queue_full | output | 1 | The queue holds DEPTH entries |
| underrun | output | 1 | Sticky: a period ended with no successor queued |
| overflow | output | 1 | Sticky: a command was dropped because the queue was full |

## Verification
Directed sequences cover the following cases:
- A lone pixel started from idle, which separates the two-cycle start latency from an off-by-one in the period counter.
- A queued chain that mixes a dark pixel, a saturated pixel and a zero-length entry. It shows whether a reload leaves a gap, whether clamping works, and whether a zero-length command leaks into the output.
- A burst of long periods that fills the queue and tests the drop-and-flag path.

Seeded random traffic with short periods then runs the block through simultaneous push and pop, pushes that arrive in the final period cycle (and so come too late), and clear-versus-set collisions. A cycle-level reference model built from the requirements checks every output in every cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_MARK  = 2'd1,
        PS_SPACE = 2'd2
    } pps_state_e;

endpackage

// File: rtl/pps_cmd_queue.sv
module pps_cmd_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;

    logic do_push;
    logic do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slot[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/pps_pulse_fsm.sv
module pps_pulse_fsm
    import pps_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_empty,
    input  logic [CNT_W-1:0] head_on,
    input  logic [CNT_W-1:0] head_len,
    output logic             pop,
    output logic             starve,
    output logic             laser_on,
    output logic             busy
);
    pps_state_e       state, state_n;
    logic [CNT_W-1:0] mark_r, mark_n;
    logic [CNT_W-1:0] len_r, len_n;
    logic [CNT_W-1:0] pos_r, pos_n;

    logic             last_cyc;
    logic             mark_done;
    logic [CNT_W-1:0] head_mark;

    // clamp the mark time to the period length
    assign head_mark = (head_on >= head_len) ? head_len : head_on;
    assign last_cyc  = (pos_r == (len_r - CNT_W'(1)));
    assign mark_done = ((pos_r + CNT_W'(1)) == mark_r);

    always_comb begin
        state_n = state;
        mark_n  = mark_r;
        len_n   = len_r;
        pos_n   = pos_r;
        pop     = 1'b0;
        starve  = 1'b0;
        unique case (state)
            PS_IDLE: begin
                if (!q_empty) begin
                    pop     = 1'b1;
                    mark_n  = head_mark;
                    len_n   = head_len;
                    pos_n   = '0;
                    state_n = (head_mark == '0) ? PS_SPACE : PS_MARK;
                end
            end
            PS_MARK, PS_SPACE: begin
                if (last_cyc) begin
                    if (!q_empty) begin
                        pop     = 1'b1;
                        mark_n  = head_mark;
                        len_n   = head_len;
                        pos_n   = '0;
                        state_n = (head_mark == '0) ? PS_SPACE : PS_MARK;
                    end else begin
                        starve  = 1'b1;
                        pos_n   = '0;
                        state_n = PS_IDLE;
                    end
                end else begin
                    pos_n = pos_r + CNT_W'(1);
                    if ((state == PS_MARK) && mark_done) begin
                        state_n = PS_SPACE;
                    end
                end
            end
            default: state_n = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            mark_r <= '0;
            len_r  <= '0;
            pos_r  <= '0;
        end else begin
            state  <= state_n;
            mark_r <= mark_n;
            len_r  <= len_n;
            pos_r  <= pos_n;
        end
    end

    always_comb begin
        laser_on = 1'b0;
        busy     = 1'b0;
        unique case (state)
            PS_IDLE:  begin laser_on = 1'b0; busy = 1'b0; end
            PS_MARK:  begin laser_on = 1'b1; busy = 1'b1; end
            PS_SPACE: begin laser_on = 1'b0; busy = 1'b1; end
            default:  begin laser_on = 1'b0; busy = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pps_flags.sv
module pps_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_starve,
    input  logic set_drop,
    input  logic clr,
    output logic underrun,
    output logic overflow
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underrun <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (set_starve) begin
                underrun <= 1'b1;
            end else if (clr) begin
                underrun <= 1'b0;
            end
            if (set_drop) begin
                overflow <= 1'b1;
            end else if (clr) begin
                overflow <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pixel_pulse_sequencer.sv
module pixel_pulse_sequencer #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CNT_W-1:0] cmd_on,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic             clr_flags,
    output logic             cmd_accept,
    output logic             laser_on,
    output logic             busy,
    output logic             queue_full,
    output logic             underrun,
    output logic             overflow
);
    localparam int ENT_W = 2 * CNT_W;

    logic             q_push;
    logic             q_pop;
    logic             q_empty;
    logic             q_full;
    logic [ENT_W-1:0] q_head;
    logic             starve;
    logic             drop;

    assign q_push     = cmd_valid && !q_full && (cmd_len != '0);
    assign drop       = cmd_valid && q_full;
    assign cmd_accept = !q_full;
    assign queue_full = q_full;

    pps_cmd_queue #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({cmd_on, cmd_len}),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    pps_pulse_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_empty  (q_empty),
        .head_on  (q_head[ENT_W-1:CNT_W]),
        .head_len (q_head[CNT_W-1:0]),
        .pop      (q_pop),
        .starve   (starve),
        .laser_on (laser_on),
        .busy     (busy)
    );

    pps_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_starve (starve),
        .set_drop   (drop),
        .clr        (clr_flags),
        .underrun   (underrun),
        .overflow   (overflow)
    );

endmodule

// File: rtl/pixel_pulse_sequencer_chk.sv
module pixel_pulse_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic clr_flags,
    input logic laser_on,
    input logic busy,
    input logic queue_full,
    input logic underrun,
    input logic overflow
);
    AST_DROP_RAISES_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && queue_full |=> overflow); // R6

    AST_FULL_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full |-> busy); // R6

    AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !clr_flags |=> underrun); // R7

    AST_OVERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !clr_flags |=> overflow); // R7

    AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !laser_on); // R9

    AST_STOP_FLAGS_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> underrun); // R4

endmodule

bind pixel_pulse_sequencer pixel_pulse_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .clr_flags  (clr_flags),
    .laser_on   (laser_on),
    .busy       (busy),
    .queue_full (queue_full),
    .underrun   (underrun),
    .overflow   (overflow)
);

// File: tb/pixel_pulse_sequencer_tb.sv
module pixel_pulse_sequencer_tb;
    localparam int CNT_W = 16;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [CNT_W-1:0] cmd_on = '0;
    logic [CNT_W-1:0] cmd_len = '0;
    logic             clr_flags = 1'b0;
    logic             cmd_accept, laser_on, busy, queue_full, underrun, overflow;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // reference model state
    int m_qon[$];
    int m_qlen[$];
    bit m_run = 0;
    int m_on = 0, m_len = 0, m_pos = 0;
    bit m_ur = 0, m_ov = 0;

    always #10 clk = ~clk;

    pixel_pulse_sequencer #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
        .cmd_len(cmd_len), .clr_flags(clr_flags), .cmd_accept(cmd_accept),
        .laser_on(laser_on), .busy(busy), .queue_full(queue_full),
        .underrun(underrun), .overflow(overflow)
    );

    function automatic bit exp_laser();
        int mk;
        mk = (m_on < m_len) ? m_on : m_len;
        return m_run && (m_pos < mk);
    endfunction

    function automatic bit exp_full();
        return m_qon.size() == DEPTH;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 laser_on", laser_on, exp_laser());
        check("R9 busy", busy, m_run);
        check("R6 queue_full", queue_full, exp_full());
        check("R1 cmd_accept", cmd_accept, !exp_full());
        check("R7 underrun", underrun, m_ur);
        check("R6 overflow", overflow, m_ov);
    endtask

    // advance the model across one clock edge with the given inputs
    task automatic model_step(input bit v, input int on, input int len, input bit clr);
        bit full_now, endp, pop, push, ur_set, ov_set;
        full_now = exp_full();
        ov_set   = v && full_now;
        push     = v && !full_now && (len != 0);
        endp     = m_run && (m_pos == m_len - 1);
        pop      = (!m_run || endp) && (m_qon.size() > 0);
        ur_set   = endp && (m_qon.size() == 0);
        if (pop) begin
            m_on  = m_qon.pop_front();
            m_len = m_qlen.pop_front();
            m_pos = 0;
            m_run = 1;
        end else if (endp) begin
            m_run = 0;
            m_pos = 0;
        end else if (m_run) begin
            m_pos++;
        end
        if (push) begin
            m_qon.push_back(on);
            m_qlen.push_back(len);
        end
        m_ur = ur_set ? 1'b1 : (clr ? 1'b0 : m_ur);
        m_ov = ov_set ? 1'b1 : (clr ? 1'b0 : m_ov);
    endtask

    // one cycle: compare at the falling edge, then drive and step the model
    task automatic cycle(input bit v, input int on, input int len, input bit clr);
        @(negedge clk);
        compare_all();
        cmd_valid = v;
        cmd_on    = CNT_W'(on);
        cmd_len   = CNT_W'(len);
        clr_flags = clr;
        model_step(v, on, len, clr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int busy_cnt, laser_cnt, rises;
        bit prev_busy;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        @(negedge clk);
        check("R10 laser_on", laser_on, 1'b0);
        check("R10 busy", busy, 1'b0);
        check("R10 queue_full", queue_full, 1'b0);
        check("R10 cmd_accept", cmd_accept, 1'b1);
        check("R10 underrun", underrun, 1'b0);
        check("R10 overflow", overflow, 1'b0);

        // R5: single pixel from idle, starts two cycles after offer
        cycle(1, 2, 4, 0);
        cycle(0, 0, 0, 0);
        check("R5 idle one cycle after offer", busy, 1'b0);
        cycle(0, 0, 0, 0);
        check("R5 period started", busy, 1'b1);
        check("R2 first cycle lit", laser_on, 1'b1);
        repeat (6) cycle(0, 0, 0, 0);
        check("R7 underrun after lone pixel", underrun, 1'b1);
        cycle(0, 0, 0, 1);
        cycle(0, 0, 0, 0);
        check("R7 cleared", underrun, 1'b0);

        // R4 R3 R8: chain with partial, dark, zero-length and saturated pixels
        busy_cnt = 0; laser_cnt = 0; rises = 0; prev_busy = 0;
        for (int i = 0; i < 20; i++) begin
            case (i)
                0: cycle(1, 1, 3, 0);
                1: cycle(1, 0, 2, 0);
                2: cycle(1, 3, 0, 0);
                3: cycle(1, 5, 2, 0);
                default: cycle(0, 0, 0, 0);
            endcase
            if (busy) busy_cnt++;
            if (laser_on) laser_cnt++;
            if (busy && !prev_busy) rises++;
            prev_busy = busy;
        end
        n_checks++;
        if (busy_cnt != 7) begin
            n_errors++;
            $display("FAIL R8 busy cycles: actual=%0d expected=7", busy_cnt);
        end
        n_checks++;
        if (laser_cnt != 3) begin
            n_errors++;
            $display("FAIL R3 lit cycles: actual=%0d expected=3", laser_cnt);
        end
        n_checks++;
        if (rises != 1) begin
            n_errors++;
            $display("FAIL R4 busy starts: actual=%0d expected=1", rises);
        end
        cycle(0, 0, 0, 1);

        // R6: fill the queue with long periods and overrun it
        for (int i = 0; i < 6; i++) cycle(1, 1, 50, 0);
        cycle(0, 0, 0, 0);
        check("R6 queue full", queue_full, 1'b1);
        check("R1 accept low when full", cmd_accept, 1'b0);
        check("R6 overflow set", overflow, 1'b1);
        repeat (10) cycle(0, 0, 0, 0);
        check("R7 overflow sticky", overflow, 1'b1);
        repeat (300) cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 1);
        cycle(0, 0, 0, 0);
        check("R7 flags cleared", overflow, 1'b0);

        // random traffic
        for (int i = 0; i < 5000; i++) begin
            bit v, c;
            v = ($urandom_range(0, 9) < 6);
            c = ($urandom_range(0, 19) == 0);
            cycle(v, int'($urandom_range(0, 7)), int'($urandom_range(0, 6)), c);
        end
        repeat (50) cycle(0, 0, 0, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule